// File: doc/BRIEF.md
# Interrupt Redirection Table Controller

This block is an I/O interrupt controller with 24 input pins. Each pin owns a 64-bit routing entry. The entry gives the vector, the trigger kind, the mask, the destination and delivery modes, and an 8-bit target ID. Software reaches the entries indirectly: it writes an index into a select register and then reads or writes a 32-bit data window.

Interrupt sources never drive pin levels directly. They issue assert, deassert or pulse requests. Each pin keeps a signed assert count, so several sources that share one pin combine correctly, and only the move of that count from zero to one produces a delivery. Deliveries leave on a valid/ready handshake toward the local interrupt controllers, carrying the vector, the target ID, a broadcast flag and a level flag.

Level-triggered pins use a remote-IRR handshake. Delivery sets the bit. An end-of-interrupt (EOI) broadcast for the matching vector clears it and fires the pin again if its line is still asserted. A write to an entry can also release a held interrupt.

The delivery engine has two states:
- `ST_IDLE`: the engine takes the lowest-numbered pending pin. If the entry is eligible, it takes the transition IDLE→SEND. If not, it drops the request and stays in IDLE.
- `ST_SEND`: the engine holds the request on the output. It takes the transition SEND→IDLE when `irq_ready` is high.

Top module: `irq_redir_ctrl`

## Requirements
- R1: Register access works as follows. A write at address 0x00 loads the select index, keeping only the low 8 bits, and a read at 0x00 returns that index. Address 0x10 is the data window. Index 0x01 reads 0x00170011, which is the entry count minus one in bits 23:16 and code 0x11 in bits 7:0. Index 0x10+2p is the low half of the entry for pin p, and index 0x11+2p is its high half.
- R2: After reset:
  - every entry reads 0x00010000 in its low half and 0 in its high half, so every pin is masked;
  - `irq_valid` and `cnt_err` are 0;
  - all assert counts are zero.
- R3: The entry bit layout is:
  - bits 7:0: vector;
  - bits 10:8: delivery mode, where 000 means fixed;
  - bit 11: destination mode, where 0 means physical;
  - bit 12: delivery status;
  - bit 14: remote IRR;
  - bit 15: trigger, where 1 means level;
  - bit 16: mask;
  - bits 63:56: target ID.
  Bits 12 and 14 are read-only: a write to either half leaves them unchanged.
- R4: Request op codes are 01 assert (count +1), 10 deassert (count −1) and 11 pulse. A delivery is requested only when the count moves from 0 to 1. No other count change produces one.
- R5: A pulse acts as an assert followed at once by a deassert. It fires if the count was 0, and it leaves the count unchanged.
- R6: A pin is delivered only if it is unmasked, its destination mode is physical and its delivery mode is fixed. Otherwise the request is dropped without any output.
- R7: Delivering a level-triggered pin sets its remote-IRR bit. Delivering an edge-triggered pin leaves that bit clear.
- R8: After a write to either half of an entry, the pin is delivered if it is unmasked, its remote IRR is clear and its count is above zero.
- R9: An EOI for vector V clears remote IRR on every pin whose remote IRR is set and whose vector is V. Each such pin with a count above zero is delivered again, in ascending pin order.
- R10: On the output handshake, `irq_valid` and all fields hold steady until `irq_ready` is high, and each handshake is exactly one delivery. `irq_bcast` is 1 exactly when the target ID is 0xFF.
- R11: A deassert or pulse that leaves a count below zero sets the sticky flag `cnt_err`. The count saturates at its lower bound, and a later assert from -1 reaching 0 does not deliver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address (0x00 select, 0x10 window) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| pin_req_valid | input | 1 | Pin request strobe |
| pin_req_pin | input | 5 | Pin number of the request |
| pin_req_op | input | 2 | Request op: 01 assert, 10 deassert, 11 pulse |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being acknowledged |
| irq_valid | output | 1 | Delivery request valid |
| irq_ready | input | 1 | Downstream accepts delivery |
| irq_vector | output | 8 | Delivered vector |
| irq_dest | output | 8 | Target ID |
| irq_bcast | output | 1 | Broadcast to all targets |
| irq_level | output | 1 | Delivery is level-triggered |
| cnt_err | output | 1 | Sticky assert-count underflow flag |

## Verification
The bench uses several stimulus patterns, and each one separates specific behaviours:
- Repeated asserts on one shared pin separate counting from level following: only the first assert may deliver.
- Pulses on an idle pin show that the count returns to zero.
- Masked entries, logical-mode entries and non-fixed entries separate the three drop conditions from one another.
- A level pin driven through wrong-vector and right-vector EOIs, with the line held and then released, separates re-delivery from a plain IRR clear.
- Two level pins sharing a vector, released by a single EOI while the output is stalled, show ascending order and hold-until-ready behaviour.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

    // Addresses of the register port
    localparam logic [7:0] SEL_OFF  = 8'h00;
    localparam logic [7:0] WIN_OFF  = 8'h10;
    localparam logic [7:0] IDX_VER  = 8'h01;
    localparam logic [7:0] IDX_TBL  = 8'h10;
    localparam logic [7:0] VER_CODE = 8'h11;

    // Entry field positions
    localparam int B_DELMODE_LO = 8;
    localparam int B_DESTMODE   = 11;
    localparam int B_DELIVS     = 12;
    localparam int B_RIRR       = 14;
    localparam int B_TRIG       = 15;
    localparam int B_MASK       = 16;
    localparam int B_DEST_LO    = 56;

    localparam logic [63:0] RO_BITS = (64'd1 << B_DELIVS) | (64'd1 << B_RIRR);

    typedef enum logic [1:0] {
        OP_NONE     = 2'b00,
        OP_ASSERT   = 2'b01,
        OP_DEASSERT = 2'b10,
        OP_PULSE    = 2'b11
    } pin_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } dlv_state_e;

    // Per-pin routing summary handed to the delivery engine
    typedef struct packed {
        logic       ok;
        logic       level;
        logic [7:0] vector;
        logic [7:0] dest;
    } dlv_info_t;

    typedef struct packed {
        logic [7:0] vector;
        logic [7:0] dest;
        logic       level;
    } irq_msg_t;

endpackage

// File: rtl/irq_pin_counter.sv
module irq_pin_counter
    import irq_redir_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_en,
    input  pin_op_e req_op,
    output logic    fire,
    output logic    active,
    output logic    underflow
);
    localparam logic signed [CNT_W-1:0] CMAX = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic signed [CNT_W-1:0] CMIN = {1'b1, {(CNT_W-1){1'b0}}};
    localparam logic signed [CNT_W-1:0] ZERO = '0;
    localparam logic signed [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic signed [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d     = cnt_q;
        fire      = 1'b0;
        underflow = 1'b0;
        if (req_en) begin
            unique case (req_op)
                OP_ASSERT: begin
                    fire = (cnt_q == ZERO);
                    if (cnt_q != CMAX) cnt_d = cnt_q + ONE;
                end
                OP_DEASSERT: begin
                    underflow = (cnt_q <= ZERO);
                    if (cnt_q != CMIN) cnt_d = cnt_q - ONE;
                end
                OP_PULSE: begin
                    fire      = (cnt_q == ZERO);
                    underflow = (cnt_q < ZERO);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= ZERO;
        else        cnt_q <= cnt_d;
    end

    assign active = (cnt_q > ZERO);

endmodule

// File: rtl/irq_redir_table.sv
module irq_redir_table
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           reg_wr,
    input  logic [7:0]                     reg_addr,
    input  logic [31:0]                    reg_wdata,
    output logic [31:0]                    reg_rdata,
    input  logic [NUM_PINS-1:0]            set_rirr,
    input  logic                           eoi_valid,
    input  logic [7:0]                     eoi_vector,
    output dlv_info_t [NUM_PINS-1:0]       info,
    output logic [NUM_PINS-1:0]            wr_kick,
    output logic [NUM_PINS-1:0]            eoi_hit
);
    localparam int TBL_END = int'(IDX_TBL) + 2 * NUM_PINS;

    logic [7:0]  sel_q;
    logic [7:0]  tbl_off;
    logic [6:0]  win_pin;
    logic        win_tbl, win_hi;
    logic [63:0] wdata64, wmask64;
    logic [NUM_PINS-1:0][31:0] ent_lo, ent_hi;

    assign tbl_off = sel_q - IDX_TBL;
    assign win_pin = tbl_off[7:1];
    assign win_hi  = tbl_off[0];
    assign win_tbl = (sel_q >= IDX_TBL) && (int'(sel_q) < TBL_END);
    assign wdata64 = win_hi ? {reg_wdata, 32'h0} : {32'h0, reg_wdata};
    assign wmask64 = win_hi ? {32'hFFFF_FFFF, 32'h0} : {32'h0, 32'hFFFF_FFFF};

    always_ff @(posedge clk) begin
        if (!rst_n)                             sel_q <= '0;
        else if (reg_wr && reg_addr == SEL_OFF) sel_q <= reg_wdata[7:0];
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_ent
        logic [63:0] ent_q, ent_d, merged;
        logic        hit;

        assign hit    = reg_wr && (reg_addr == WIN_OFF) && win_tbl && (win_pin == 7'(p));
        assign merged = (ent_q & (~wmask64 | RO_BITS)) | (wdata64 & ~RO_BITS);

        always_comb begin
            ent_d = hit ? merged : ent_q;
            if (eoi_hit[p])  ent_d[B_RIRR] = 1'b0;
            if (set_rirr[p]) ent_d[B_RIRR] = 1'b1;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) ent_q <= 64'd1 << B_MASK;
            else        ent_q <= ent_d;
        end

        assign eoi_hit[p] = eoi_valid && ent_q[B_RIRR] && (ent_q[7:0] == eoi_vector);
        assign wr_kick[p] = hit && !merged[B_MASK] && !ent_q[B_RIRR];
        assign info[p]    = '{ok:     !ent_q[B_MASK] && !ent_q[B_DESTMODE]
                                      && (ent_q[B_DELMODE_LO +: 3] == 3'b000),
                              level:  ent_q[B_TRIG],
                              vector: ent_q[7:0],
                              dest:   ent_q[B_DEST_LO +: 8]};
        assign ent_lo[p]  = ent_q[31:0];
        assign ent_hi[p]  = ent_q[63:32];
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == SEL_OFF) begin
            reg_rdata = {24'h0, sel_q};
        end else if (reg_addr == WIN_OFF) begin
            if (sel_q == IDX_VER) begin
                reg_rdata = {8'h00, 8'(NUM_PINS - 1), 8'h00, VER_CODE};
            end else if (win_tbl) begin
                for (int p = 0; p < NUM_PINS; p++)
                    if (win_pin == 7'(p)) reg_rdata = win_hi ? ent_hi[p] : ent_lo[p];
            end
        end
    end

endmodule

// File: rtl/irq_deliver_fsm.sv
module irq_deliver_fsm
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_PINS-1:0]      pend,
    input  dlv_info_t [NUM_PINS-1:0] info,
    input  logic                     irq_ready,
    output logic [NUM_PINS-1:0]      take,
    output logic [NUM_PINS-1:0]      set_rirr,
    output logic                     irq_valid,
    output irq_msg_t                 msg
);
    dlv_state_e state_q, state_d;
    irq_msg_t   msg_d;

    // State and message register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            msg     <= '0;
        end else begin
            state_q <= state_d;
            msg     <= msg_d;
        end
    end

    // Next state, pin selection and remote-IRR update
    always_comb begin
        logic found;
        found    = 1'b0;
        take     = '0;
        set_rirr = '0;
        state_d  = state_q;
        msg_d    = msg;
        unique case (state_q)
            ST_IDLE: begin
                for (int p = 0; p < NUM_PINS; p++) begin
                    if (pend[p] && !found) begin
                        found   = 1'b1;
                        take[p] = 1'b1;
                        if (info[p].ok) begin
                            set_rirr[p] = info[p].level;
                            msg_d       = '{vector: info[p].vector,
                                            dest:   info[p].dest,
                                            level:  info[p].level};
                            state_d     = ST_SEND;
                        end
                    end
                end
            end
            ST_SEND: begin
                if (irq_ready) state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        irq_valid = (state_q == ST_SEND);
    end

endmodule

// File: rtl/irq_redir_ctrl.sv
module irq_redir_ctrl
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int CNT_W    = 4,
    parameter int PIN_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [7:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             pin_req_valid,
    input  logic [PIN_W-1:0] pin_req_pin,
    input  logic [1:0]       pin_req_op,
    input  logic             eoi_valid,
    input  logic [7:0]       eoi_vector,
    output logic             irq_valid,
    input  logic             irq_ready,
    output logic [7:0]       irq_vector,
    output logic [7:0]       irq_dest,
    output logic             irq_bcast,
    output logic             irq_level,
    output logic             cnt_err
);
    logic [NUM_PINS-1:0] fire_vec, active_vec, under_vec;
    logic [NUM_PINS-1:0] wr_kick, eoi_hit, pend_q;
    logic [NUM_PINS-1:0] take_vec, set_rirr_vec;
    dlv_info_t [NUM_PINS-1:0] info;
    irq_msg_t msg;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_cnt
        irq_pin_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_en    (pin_req_valid && (pin_req_pin == PIN_W'(p))),
            .req_op    (pin_op_e'(pin_req_op)),
            .fire      (fire_vec[p]),
            .active    (active_vec[p]),
            .underflow (under_vec[p])
        );
    end

    irq_redir_table #(.NUM_PINS(NUM_PINS)) u_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .set_rirr   (set_rirr_vec),
        .eoi_valid  (eoi_valid),
        .eoi_vector (eoi_vector),
        .info       (info),
        .wr_kick    (wr_kick),
        .eoi_hit    (eoi_hit)
    );

    irq_deliver_fsm #(.NUM_PINS(NUM_PINS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (pend_q),
        .info      (info),
        .irq_ready (irq_ready),
        .take      (take_vec),
        .set_rirr  (set_rirr_vec),
        .irq_valid (irq_valid),
        .msg       (msg)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            cnt_err <= 1'b0;
        end else begin
            pend_q  <= (pend_q & ~take_vec) | fire_vec
                     | ((wr_kick | eoi_hit) & active_vec);
            cnt_err <= cnt_err | (|under_vec);
        end
    end

    assign irq_vector = msg.vector;
    assign irq_dest   = msg.dest;
    assign irq_level  = msg.level;
    assign irq_bcast  = (msg.dest == 8'hFF);

endmodule

// File: rtl/irq_redir_chk.sv
module irq_redir_chk #(
    parameter int NUM_PINS = 24
) (
    input logic                clk,
    input logic                rst_n,
    input logic                irq_valid,
    input logic                irq_ready,
    input logic [7:0]          irq_vector,
    input logic [7:0]          irq_dest,
    input logic                irq_level,
    input logic                cnt_err,
    input logic [NUM_PINS-1:0] take_vec,
    input logic [NUM_PINS-1:0] set_rirr_vec
);
    // R10
    hold_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid && !irq_ready |=> irq_valid && $stable(irq_vector)
                                    && $stable(irq_dest) && $stable(irq_level));

    // R10
    rise_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_valid) |-> $past(|take_vec));

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_err |=> cnt_err);

    // R9
    one_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take_vec));

    // R7
    level_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_rirr_vec) |=> irq_valid && irq_level);

endmodule

bind irq_redir_ctrl irq_redir_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_valid    (irq_valid),
    .irq_ready    (irq_ready),
    .irq_vector   (irq_vector),
    .irq_dest     (irq_dest),
    .irq_level    (irq_level),
    .cnt_err      (cnt_err),
    .take_vec     (take_vec),
    .set_rirr_vec (set_rirr_vec)
);

// File: tb/tb_irq_redir_ctrl.sv
module tb_irq_redir_ctrl;
    import irq_redir_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        pin_req_valid = 1'b0;
    logic [4:0]  pin_req_pin = 5'h0;
    logic [1:0]  pin_req_op = 2'b00;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = 8'h0;
    logic        irq_valid, irq_ready = 1'b1;
    logic [7:0]  irq_vector, irq_dest;
    logic        irq_bcast, irq_level, cnt_err;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R2";
    irq_msg_t exp_q[$];

    always #5 clk = ~clk;

    irq_redir_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_req_valid(pin_req_valid), .pin_req_pin(pin_req_pin), .pin_req_op(pin_req_op),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_vector(irq_vector),
        .irq_dest(irq_dest), .irq_bcast(irq_bcast), .irq_level(irq_level),
        .cnt_err(cnt_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare every completed handshake with the scoreboard
    always @(negedge clk) begin
        if (rst_n && irq_valid && irq_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, {cur_tag, " unexpected delivery"},
                    {39'h0, irq_vector, irq_dest, irq_level}, 64'h0);
            end else begin
                irq_msg_t e;
                e = exp_q.pop_front();
                chk(irq_vector == e.vector && irq_dest == e.dest && irq_level == e.level
                    && irq_bcast == (e.dest == 8'hFF),
                    {cur_tag, " delivery R10"},
                    {38'h0, irq_vector, irq_dest, irq_level, irq_bcast},
                    {38'h0, e.vector, e.dest, e.level, e.dest == 8'hFF});
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_idx(input logic [7:0] idx, output logic [31:0] d);
        wr(SEL_OFF, {24'h0, idx});
        reg_addr = WIN_OFF;
        #1 d = reg_rdata;
    endtask

    task automatic set_entry(input int p, input logic [31:0] lo, input logic [31:0] hi);
        wr(SEL_OFF, 32'(16 + 2 * p + 1)); wr(WIN_OFF, hi);
        wr(SEL_OFF, 32'(16 + 2 * p));     wr(WIN_OFF, lo);
    endtask

    task automatic pin(input int p, input logic [1:0] op);
        pin_req_pin = 5'(p); pin_req_op = op; pin_req_valid = 1'b1;
        @(negedge clk);
        pin_req_valid = 1'b0;
    endtask

    task automatic eoi(input logic [7:0] v);
        eoi_vector = v; eoi_valid = 1'b1;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    task automatic expect_irq(input logic [7:0] v, input logic [7:0] d, input logic l);
        exp_q.push_back('{vector: v, dest: d, level: l});
    endtask

    task automatic settle();
        tick(8);
        chk(exp_q.size() == 0, {cur_tag, " expected deliveries missing"}, exp_q.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [31:0] d;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R2 reset state
        cur_tag = "R2";
        chk(irq_valid == 1'b0 && cnt_err == 1'b0, "R2 outputs idle", {irq_valid, cnt_err}, 0);
        rd_idx(8'h10, d); chk(d == 32'h0001_0000, "R2 pin0 low", d, 32'h0001_0000);
        rd_idx(8'h11, d); chk(d == 32'h0, "R2 pin0 high", d, 0);
        rd_idx(8'h3E, d); chk(d == 32'h0001_0000, "R2 pin23 low", d, 32'h0001_0000);

        // R1 select register and version
        cur_tag = "R1";
        wr(SEL_OFF, 32'h0000_01FF); reg_addr = SEL_OFF; #1;
        chk(reg_rdata == 32'hFF, "R1 select low 8 bits", reg_rdata, 32'hFF);
        wr(SEL_OFF, 32'h0000_0101); reg_addr = WIN_OFF; #1;
        chk(reg_rdata == 32'h0017_0011, "R1 version via truncated select", reg_rdata, 32'h0017_0011);

        // R8/R4 edge pin 3
        cur_tag = "R4";
        set_entry(3, 32'h0000_0041, 32'h0500_0000);
        settle();                                   // R8: count zero, no delivery
        expect_irq(8'h41, 8'h05, 1'b0);
        pin(3, OP_ASSERT); settle();
        pin(3, OP_ASSERT); settle();                // R4: 1->2 ignored
        pin(3, OP_DEASSERT); pin(3, OP_DEASSERT); settle();
        expect_irq(8'h41, 8'h05, 1'b0);
        pin(3, OP_ASSERT); settle();
        pin(3, OP_DEASSERT); settle();
        cur_tag = "R7";
        rd_idx(8'h16, d); chk(d == 32'h0000_0041, "R7 edge leaves IRR clear", d, 32'h41);

        // R5 pulses
        cur_tag = "R5";
        expect_irq(8'h41, 8'h05, 1'b0); pin(3, OP_PULSE); settle();
        expect_irq(8'h41, 8'h05, 1'b0); pin(3, OP_PULSE); settle();

        // R6 drop conditions, R8 unmask release
        cur_tag = "R6";
        set_entry(4, 32'h0001_0050, 32'h0400_0000);
        pin(4, OP_ASSERT); settle();
        set_entry(5, 32'h0000_0851, 32'h0400_0000);
        pin(5, OP_ASSERT); settle();
        set_entry(6, 32'h0000_0152, 32'h0400_0000);
        pin(6, OP_ASSERT); settle();
        cur_tag = "R8";
        expect_irq(8'h50, 8'h04, 1'b0);
        wr(SEL_OFF, 32'h18); wr(WIN_OFF, 32'h0000_0050); settle();
        pin(4, OP_DEASSERT);

        // R7/R3/R9 level pin 7 with broadcast target
        cur_tag = "R7";
        set_entry(7, 32'h0000_8060, 32'hFF00_0000);
        expect_irq(8'h60, 8'hFF, 1'b1);
        pin(7, OP_ASSERT); settle();
        rd_idx(8'h1E, d); chk(d == 32'h0000_C060, "R7 level sets IRR", d, 32'hC060);
        cur_tag = "R3";
        wr(WIN_OFF, 32'h0000_9060); settle();       // IRR set: R8 no release
        rd_idx(8'h1E, d); chk(d == 32'h0000_C060, "R3 read-only bits kept", d, 32'hC060);
        cur_tag = "R9";
        eoi(8'h61); settle();
        expect_irq(8'h60, 8'hFF, 1'b1);
        eoi(8'h60); settle();
        pin(7, OP_DEASSERT);
        eoi(8'h60); settle();
        rd_idx(8'h1E, d); chk(d == 32'h0000_8060, "R9 EOI clears IRR", d, 32'h8060);

        // R9 ascending order, R10 stall
        cur_tag = "R9";
        set_entry(8, 32'h0000_8070, 32'h0100_0000);
        set_entry(9, 32'h0000_8070, 32'h0200_0000);
        expect_irq(8'h70, 8'h02, 1'b1); pin(9, OP_ASSERT); settle();
        expect_irq(8'h70, 8'h01, 1'b1); pin(8, OP_ASSERT); settle();
        irq_ready = 1'b0;
        expect_irq(8'h70, 8'h01, 1'b1);
        expect_irq(8'h70, 8'h02, 1'b1);
        eoi(8'h70); tick(5);
        cur_tag = "R10";
        chk(irq_valid && irq_dest == 8'h01, "R10 stalled output", {irq_valid, irq_dest}, {1'b1, 8'h01});
        tick(3);
        chk(irq_valid && irq_dest == 8'h01 && irq_vector == 8'h70, "R10 held fields",
            {irq_valid, irq_vector, irq_dest}, {1'b1, 8'h70, 8'h01});
        irq_ready = 1'b1;
        cur_tag = "R9";
        settle();

        // R11 underflow
        cur_tag = "R11";
        set_entry(10, 32'h0000_0080, 32'h0300_0000);
        pin(10, OP_DEASSERT); tick(2);
        chk(cnt_err == 1'b1, "R11 underflow flag", cnt_err, 1);
        pin(10, OP_ASSERT); settle();               // -1 -> 0, no delivery
        expect_irq(8'h80, 8'h03, 1'b0);
        pin(10, OP_ASSERT); settle();
        chk(cnt_err == 1'b1, "R11 flag sticky", cnt_err, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule